// File: doc/BRIEF.md
# Loadable Cascadable Synchronous Modulo Counter

This block is a synchronous binary counter made of identical 4-bit slices. Every slice updates on the same clock edge, so no value ripples from one flip-flop to the next. Each slice has four controls:

- a synchronous clear;
- a synchronous parallel load;
- two count enables, and both must be high for the slice to advance;
- a terminal-count flag, qualified by the chain enable.

The chain enable of each upper slice is the terminal-count flag of the slice below it. The default build joins two slices into an 8-bit counter.

An auto-reload input gives a modulus other than a power of two. When it is set, the counter loads a preset value at the cycle that would otherwise wrap from all-ones. The counter then passes through 256 minus the preset states. A preset of 63 gives mod-193, and a preset of 245 gives mod-11. When auto-reload is clear, the counter wraps through zero as a plain binary counter.

Top module: `mod_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `carry_out` is 0.
- R2: When `clr` is 1 at a clock edge, `count` becomes 0 after that edge, whatever the other inputs are.
- R3: When `ld` is 1 and `clr` is 0 at a clock edge, `count` takes `load_val` after that edge. This happens regardless of the enables, of `auto_reload` and of terminal count.
- R4: When `clr` and `ld` are 0, `count` increments by 1 only when both `cnt_en` and `chain_en` are 1. In every other case it holds its value.
- R5: `carry_out` is combinational and equals `chain_en` AND (`count` == 255).
- R6: The lower 4-bit slice's terminal flag enables the upper slice, so the count moves from 15 to 16 in a single edge.
- R7: When `clr` and `ld` are 0, and `auto_reload`, `cnt_en` and `carry_out` are all 1, `count` takes `preset` after the edge. A free-running counter then has a period of 256 − `preset` states, for example 193 states for a preset of 63 and 11 states for a preset of 245.
- R8: When `auto_reload` is 0, an increment from 255 gives 0.
- R9: When `cnt_en` is 0, no reload and no count occur, even while `carry_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear, highest priority |
| ld | input | 1 | Synchronous parallel load |
| cnt_en | input | 1 | Count enable shared by all slices |
| chain_en | input | 1 | Count enable of the lowest slice; also qualifies the carry |
| auto_reload | input | 1 | Load `preset` at terminal count |
| load_val | input | 8 | Value taken by `ld` |
| preset | input | 8 | Value taken at terminal count under auto-reload |
| count | output | 8 | Current count |
| carry_out | output | 1 | Terminal-count flag of the whole chain |

## Verification
Any wrong internal state appears on `count` at the very next edge, because nothing sits between the slice registers and the port. A broken carry link between slices shows up at the 15-to-16 step, where the upper nibble fails to advance. A reload that fires at the wrong time, or that ignores the enable, changes the measured period of the counter. The bench therefore counts full loops for two presets and compares the length against 256 − preset.

// File: rtl/mod_counter.sv
module ctr_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         cnt_en,
  input  logic         chain_en,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  q <= '0;
    else if (clr)                q <= '0;
    else if (ld)                 q <= d;
    else if (cnt_en && chain_en) q <= q + W'(1);

  assign tc = chain_en && (q == ALL1);

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> q == '0);
  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ld) |=> q == $past(d));
  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !(cnt_en && chain_en)) |=> $stable(q));
  // R4
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && cnt_en && chain_en) |=> q == $past(q) + W'(1));
endmodule

module mod_counter #(
  parameter int SLICE_W = 4,
  parameter int SLICES  = 2,
  localparam int TW     = SLICE_W * SLICES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld,
  input  logic          cnt_en,
  input  logic          chain_en,
  input  logic          auto_reload,
  input  logic [TW-1:0] load_val,
  input  logic [TW-1:0] preset,
  output logic [TW-1:0] count,
  output logic          carry_out
);
  logic [SLICES:0] chain;
  logic            reload, load_any;
  logic [TW-1:0]   load_data;

  assign chain[0]  = chain_en;
  assign carry_out = chain[SLICES];
  assign reload    = auto_reload && cnt_en && carry_out;
  assign load_any  = ld || reload;
  assign load_data = ld ? load_val : preset;

  for (genvar i = 0; i < SLICES; i++) begin : g_slice
    ctr_slice #(.W(SLICE_W)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .ld       (load_any),
      .d        (load_data[i*SLICE_W +: SLICE_W]),
      .cnt_en   (cnt_en),
      .chain_en (chain[i]),
      .q        (count[i*SLICE_W +: SLICE_W]),
      .tc       (chain[i+1])
    );
  end

  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && auto_reload && cnt_en && carry_out) |=> count == $past(preset));
  // R8
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !auto_reload && cnt_en && carry_out) |=> count == '0);
  // R9
  paused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !ld && !cnt_en) |=> $stable(count));
  // R5
  carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    carry_out |-> (chain_en && count == {TW{1'b1}}));
endmodule

// File: tb/sim_mod_counter.sv
module sim_mod_counter;
  logic clk = 0, rst_n = 0, clr = 0, ld = 0, cnt_en = 0, chain_en = 0, auto_reload = 0;
  logic [7:0] load_val = 0, preset = 8'd63;
  logic [7:0] count;
  logic carry_out;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  mod_counter u0 (.clk, .rst_n, .clr, .ld, .cnt_en, .chain_en, .auto_reload,
                  .load_val, .preset, .count, .carry_out);

  // {clr, ld, cnt_en, chain_en, auto_reload, load_val, exp_count, exp_carry}
  localparam int NV = 16;
  localparam logic [21:0] VEC [NV] = '{
    {5'b01000, 8'd14,  8'd14,  1'b0},  // R3 load
    {5'b00110, 8'd0,   8'd15,  1'b0},  // R4 count
    {5'b00110, 8'd0,   8'd16,  1'b0},  // R6 slice carry
    {5'b00010, 8'd0,   8'd16,  1'b0},  // R4 hold cnt_en low
    {5'b00100, 8'd0,   8'd16,  1'b0},  // R4 hold chain_en low
    {5'b11110, 8'd99,  8'd0,   1'b0},  // R2 clear beats load
    {5'b01000, 8'd254, 8'd254, 1'b0},  // R3
    {5'b00110, 8'd0,   8'd255, 1'b1},  // R5 carry
    {5'b00011, 8'd0,   8'd255, 1'b1},  // R9 no reload when paused
    {5'b00101, 8'd0,   8'd255, 1'b0},  // R5 gated by chain_en
    {5'b00110, 8'd0,   8'd0,   1'b0},  // R8 wrap
    {5'b01000, 8'd254, 8'd254, 1'b0},  // R3
    {5'b00111, 8'd0,   8'd255, 1'b1},  // R4
    {5'b00111, 8'd0,   8'd63,  1'b0},  // R7 reload
    {5'b00111, 8'd0,   8'd64,  1'b0},  // R7 continue
    {5'b01111, 8'd200, 8'd200, 1'b0}   // R3 load beats count
  };

  task automatic check(string req, logic [7:0] ac, logic [7:0] ex, logic acy, logic exy);
    checks++;
    if (ac !== ex || acy !== exy) begin
      fails++;
      $display("FAIL %s: count=%0d carry=%0b expected count=%0d carry=%0b", req, ac, acy, ex, exy);
    end
  endtask

  task automatic period(logic [7:0] p, int exp, string req);
    int n = 0;
    @(negedge clk);
    preset = p; load_val = p; ld = 1; clr = 0;
    @(negedge clk);
    ld = 0; cnt_en = 1; chain_en = 1; auto_reload = 1;
    do begin
      @(negedge clk);
      n++;
    end while (count !== p && n < 400);
    checks++;
    if (n != exp) begin
      fails++;
      $display("FAIL %s: period=%0d expected %0d", req, n, exp);
    end
  endtask

  initial begin
    #1;
    check("R1", count, 8'd0, carry_out, 1'b0);
    #20 rst_n = 1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {clr, ld, cnt_en, chain_en, auto_reload} = VEC[i][21:17];
      load_val = VEC[i][16:9];
      @(posedge clk);
      #1;
      check($sformatf("vector %0d", i), count, VEC[i][8:1], carry_out, VEC[i][0]);
    end
    period(8'd63, 193, "R7 mod-193");
    period(8'd245, 11, "R7 mod-11");
    @(negedge clk);
    rst_n = 0;
    #1;
    check("R1 reset mid-run", count, 8'd0, carry_out, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: count=%0d expected end of run", count);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule